// File: doc/BRIEF.md
# DRAM Auto-Refresh Command Sequencer

This block lives inside a mobile DDR SDRAM controller and takes over the memory command bus whenever the main scheduler asks for a refresh. If the scheduler reports that a bank is open, the block first closes every bank with a single precharge that has the all-banks address bit set. It then waits out the precharge recovery time. After that it issues one or two AUTO REFRESH commands, and each one is followed by the full refresh cycle time. While it waits it drives NOP only, and CKE stays high for the whole period.

The request is a level handshake. The scheduler raises `rf_req` and holds the command bus for the sequencer while `rf_busy` is high. A one-cycle `rf_ack` marks the point where the last refresh cycle time has run out. At that same edge `rf_busy` falls, and the scheduler may place an ACTIVE command on the bus in the very next cycle. The number of refreshes is taken from `rf_two` at the edge where the request is accepted. The precharge-recovery and refresh-cycle times are parameters given in clock cycles.

Top module: `refresh_seq`

## Requirements
- R1: While reset is asserted, the command outputs read COMMAND INHIBIT ({cs_n,ras_n,cas_n,we_n} = 1111), `rf_busy`, `rf_ack` and `cke` are 0, and `cke` is 1 from the first clock edge after reset is released.
- R2: A request is accepted at a clock edge where `rf_req` is 1, the block is idle and `rf_ack` is 0. `rf_busy` reads 1 from that edge onwards.
- R3: If `any_open` is 1 at acceptance, a PRECHARGE (0010) is issued at the accepting edge. It has address bit AP_BIT (10 by default) set to 1, all other address bits 0 and bank address 0.
- R4: If `any_open` is 0 at acceptance, no PRECHARGE is issued and the first AUTO REFRESH is issued at the accepting edge.
- R5: After a PRECHARGE, the first AUTO REFRESH is issued exactly T_RP cycles later.
- R6: AUTO REFRESH is encoded 0001 and is issued with the address and bank address all zero.
- R7: `rf_two` = 1 at acceptance gives two AUTO REFRESH commands, exactly T_RFC cycles apart, and `rf_two` = 0 gives one. Changes to `rf_two` after acceptance have no effect.
- R8: While `rf_busy` is 1, every cycle that carries neither PRECHARGE nor AUTO REFRESH carries NOP (0111).
- R9: `rf_ack` is 1 for exactly one cycle, T_RFC cycles after the last AUTO REFRESH. `rf_busy` falls at the same edge, and whenever `rf_busy` is 0 the command is COMMAND INHIBIT.
- R10: `cke` is 1 in every cycle where `rf_busy` is 1.
- R11: `rf_req` held high during a sequence, or during the `rf_ack` cycle, does not start a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_req | input | 1 | Refresh request from the scheduler (level) |
| rf_two | input | 1 | 1 = two back-to-back refreshes, sampled at acceptance |
| any_open | input | 1 | 1 = at least one bank is open |
| rf_ack | output | 1 | One-cycle pulse when the sequence completes |
| rf_busy | output | 1 | Sequencer owns the command bus |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| cke | output | 1 | Clock enable |

## Verification
A wait counter that is off by one shows at the ports as an AUTO REFRESH or an `rf_ack` landing a cycle early or late relative to the preceding command. The bench catches this in the first sequence, because it compares every cycle of the command bus with a schedule computed from T_RP and T_RFC. A wrong refresh count or a lost burst selection shows up as a missing or extra AUTO REFRESH within T_RFC cycles of the first one. An FSM that fails to return to idle, or that accepts a request again, shows in the cycle right after `rf_ack`: either `rf_busy` stays high or a command other than COMMAND INHIBIT appears.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PRE_WAIT = 2'd1,
    ST_RFC_WAIT = 2'd2
  } rfsh_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_AREF = 4'b0001;
  localparam logic [3:0] CMD_INH  = 4'b1111;

  // counter width able to hold the larger of two wait lengths
  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // reload value for a wait of t cycles (next command t edges later)
  function automatic int unsigned wait_load(input int unsigned t);
    return t - 1;
  endfunction

  // number of refreshes requested by the burst select
  function automatic int unsigned refresh_count(input logic two);
    return two ? 2 : 1;
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // A new wait may only start once the previous one has fully run out
  p_load_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
  import rfsh_pkg::*;
#(
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 10,
  parameter int unsigned CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          two,
  input  logic          any_open,
  input  logic          done,
  output logic          issue_pre,
  output logic          issue_aref,
  output logic [CW-1:0] load_val,
  output logic          own_next,
  output logic          busy,
  output logic          ack
);

  localparam logic [CW-1:0] LD_RP  = CW'(wait_load(T_RP));
  localparam logic [CW-1:0] LD_RFC = CW'(wait_load(T_RFC));

  rfsh_state_e st_q, st_n;
  logic [1:0]  left_q, left_n;
  logic        ack_q;
  logic        accept;
  logic        finish;

  assign accept = (st_q == ST_IDLE) && req && !ack_q;

  always_comb begin
    st_n       = st_q;
    left_n     = left_q;
    issue_pre  = 1'b0;
    issue_aref = 1'b0;
    finish     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (any_open) begin
            issue_pre = 1'b1;
            st_n      = ST_PRE_WAIT;
            left_n    = 2'(refresh_count(two));
          end else begin
            issue_aref = 1'b1;
            st_n       = ST_RFC_WAIT;
            left_n     = 2'(refresh_count(two) - 1);
          end
        end
      end
      ST_PRE_WAIT: begin
        if (done) begin
          issue_aref = 1'b1;
          left_n     = left_q - 2'd1;
          st_n       = ST_RFC_WAIT;
        end
      end
      ST_RFC_WAIT: begin
        if (done) begin
          if (left_q != 2'd0) begin
            issue_aref = 1'b1;
            left_n     = left_q - 2'd1;
          end else begin
            finish = 1'b1;
            st_n   = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= 2'd0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      left_q <= left_n;
      ack_q  <= finish;
    end
  end

  assign load_val = issue_pre ? LD_RP : LD_RFC;
  assign own_next = (st_n != ST_IDLE);
  assign busy     = (st_q != ST_IDLE);
  assign ack      = ack_q;

  // Refresh from a wait state only when the timer has expired
  p_aref_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_aref && (st_q != ST_IDLE)) |-> done);

  // Acceptance takes the bus at the next edge
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // Acknowledge is a single-cycle pulse
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // No refresh left pending once idle
  p_idle_no_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (left_q == 2'd0));

endmodule

// File: rtl/rfsh_cmd_enc.sv
module rfsh_cmd_enc
  import rfsh_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_pre,
  input  logic              issue_aref,
  input  logic              own_next,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = {{(ADDR_W-1){1'b0}}, 1'b1} << AP_BIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd  <= CMD_INH;
      addr <= '0;
      ba   <= '0;
      cke  <= 1'b0;
    end else begin
      cke <= 1'b1;
      ba  <= '0;
      if (issue_pre) begin
        cmd  <= CMD_PRE;
        addr <= ALL_BANKS;
      end else if (issue_aref) begin
        cmd  <= CMD_AREF;
        addr <= '0;
      end else if (own_next) begin
        cmd  <= CMD_NOP;
        addr <= '0;
      end else begin
        cmd  <= CMD_INH;
        addr <= '0;
      end
    end
  end

  // Precharge always closes every bank
  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> addr[AP_BIT]);

  // Refresh carries no address information
  p_aref_zero_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_AREF) |-> ((addr == '0) && (ba == '0)));

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RFC  = 10,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_req,
  input  logic              rf_two,
  input  logic              any_open,
  output logic              rf_ack,
  output logic              rf_busy,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke
);

  localparam int unsigned CW = cnt_width(T_RP, T_RFC);

  logic          issue_pre;
  logic          issue_aref;
  logic          own_next;
  logic          wait_done;
  logic [CW-1:0] load_val;
  logic [3:0]    cmd;

  rfsh_fsm #(.T_RP(T_RP), .T_RFC(T_RFC), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (rf_req),
    .two       (rf_two),
    .any_open  (any_open),
    .done      (wait_done),
    .issue_pre (issue_pre),
    .issue_aref(issue_aref),
    .load_val  (load_val),
    .own_next  (own_next),
    .busy      (rf_busy),
    .ack       (rf_ack)
  );

  rfsh_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (issue_pre | issue_aref),
    .load_val(load_val),
    .done    (wait_done)
  );

  rfsh_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_pre (issue_pre),
    .issue_aref(issue_aref),
    .own_next  (own_next),
    .cmd       (cmd),
    .addr      (addr),
    .ba        (ba),
    .cke       (cke)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  // Clock enable stays high while the sequencer owns the bus
  p_cke_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_busy |-> cke);

  // Released bus carries only inhibit
  p_idle_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_busy |-> (cmd == CMD_INH));

  // Waiting cycles carry NOP only
  p_busy_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_busy && (cmd != CMD_PRE) && (cmd != CMD_AREF)) |-> (cmd == CMD_NOP));

  // Acknowledge coincides with bus release
  p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_ack |-> !rf_busy);

endmodule

// File: tb/sim_refresh_seq.sv
`timescale 1ns/1ps
module sim_refresh_seq;

  localparam int TRP  = 2;
  localparam int TRFC = 5;
  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int APB  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_req = 1'b0, rf_two = 1'b0, any_open = 1'b0;
  logic rf_ack, rf_busy, cs_n, ras_n, cas_n, we_n, cke;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  refresh_seq #(.T_RP(TRP), .T_RFC(TRFC), .ADDR_W(AW), .BA_W(BW), .AP_BIT(APB)) u0 (
    .clk(clk), .rst_n(rst_n), .rf_req(rf_req), .rf_two(rf_two), .any_open(any_open),
    .rf_ack(rf_ack), .rf_busy(rf_busy), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .cke(cke)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bus();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // one full sequence; k counts cycles after the accepting edge
  task automatic run_seq(input bit bo, input bit two, input bit hold);
    int pre_len, nref, k_end, exp_cmd, exp_addr;
    bit is_ref;
    pre_len = bo ? TRP : 0;
    nref    = two ? 2 : 1;
    k_end   = pre_len + nref * TRFC;
    @(negedge clk);
    rf_req = 1'b1; any_open = bo; rf_two = two;
    for (int k = 0; k <= k_end + 1; k++) begin
      @(negedge clk);
      // disturb inputs after acceptance (R7, R11)
      rf_two = ~two;
      any_open = ~bo;
      if (!hold && k == 0) rf_req = 1'b0;
      if (!hold && k == 2) rf_req = 1'b1;
      is_ref = 1'b0;
      for (int i = 0; i < nref; i++) if (k == pre_len + i * TRFC) is_ref = 1'b1;
      exp_addr = 0;
      if (k >= k_end)           exp_cmd = 4'b1111;
      else if (bo && k == 0)  begin exp_cmd = 4'b0010; exp_addr = 1 << APB; end
      else if (is_ref)          exp_cmd = 4'b0001;
      else                      exp_cmd = 4'b0111;
      if (k == 0 && bo)       chk(bus() == exp_cmd && addr == exp_addr && ba == 0, "R3 precharge all", bus(), exp_cmd);
      else if (k == 0)        chk(bus() == exp_cmd, "R4 skip precharge", bus(), exp_cmd);
      else if (k == pre_len)  chk(bus() == exp_cmd, "R5 refresh after tRP", bus(), exp_cmd);
      else if (is_ref)        chk(bus() == exp_cmd, "R7 second refresh after tRFC", bus(), exp_cmd);
      else if (k < k_end)     chk(bus() == exp_cmd, "R8 nop while waiting", bus(), exp_cmd);
      else                    chk(bus() == exp_cmd, "R11 no re-accept / R9 inhibit", bus(), exp_cmd);
      if (exp_cmd == 4'b0001) chk(addr == 0 && ba == 0, "R6 refresh address zero", int'(addr), 0);
      chk(rf_busy == (k < k_end), (k == 0) ? "R2 busy on accept" : "R9 busy window", rf_busy, k < k_end);
      chk(rf_ack == (k == k_end), "R9 ack pulse", rf_ack, k == k_end);
      if (k < k_end) chk(cke == 1'b1, "R10 cke high", cke, 1);
    end
    rf_req = 1'b0;
    @(negedge clk);
    chk(rf_busy == 1'b0 && bus() == 4'b1111, "R11 idle after release", rf_busy, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus() == 4'b1111, "R1 reset inhibit", bus(), 15);
    chk(rf_busy == 1'b0 && rf_ack == 1'b0, "R1 reset busy/ack", rf_busy, 0);
    chk(cke == 1'b0, "R1 reset cke", cke, 0);
    rf_req = 1'b1;
    @(negedge clk);
    chk(rf_busy == 1'b0, "R1 req ignored in reset", rf_busy, 0);
    rf_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke == 1'b1, "R1 cke after reset", cke, 1);
    chk(bus() == 4'b1111, "R1 idle inhibit", bus(), 15);
    for (int h = 0; h < 2; h++)
      for (int bo = 0; bo < 2; bo++)
        for (int tw = 0; tw < 2; tw++)
          run_seq(bo[0], tw[0], h[0]);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule